// File: doc/BRIEF.md
# Conditional Skip and Branch Unit

This block works out the next program counter for a small 16-bit processor's control-flow operations. It handles two kinds of operation. A relative branch adds a signed 11-bit displacement to the program counter. A compare-and-skip operation tests two 16-bit operands, and when its condition holds it steps over the following two-byte instruction. Eight conditions exist: equality and inequality, signed and unsigned ordering, and two bit tests on the bitwise AND of the operands.

The program counter presented at the input already points at the instruction after the current one. A failed skip therefore leaves it unchanged. A taken skip adds the skip distance. A branch adds the sign-extended displacement. All sums wrap modulo 2^16. The second operand of a compare comes either from a register value or from a 4-bit immediate that is zero-extended. The result and a taken flag are registered, so they appear one clock after a valid request. Instruction fetch and register file access belong to neighbouring blocks.

Top module: `skip_branch_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it goes high with no request, `next_pc_o` is 0x0000 and both `taken_o` and `valid_o` are 0.
- R2: Operation code 0 (branch) gives `next_pc_o` = `pc_i` + sign-extended `offset_i`, modulo 2^16, with `taken_o` = 1.
- R3: Code 1 skips when the operands are equal. Code 2 skips when they differ.
- R4: Code 3 skips when operand A is less than operand B as signed 16-bit values. Code 4 skips when A is greater than or equal to B as signed values.
- R5: Code 5 skips when A is less than B as unsigned values. Code 6 skips when A is greater than or equal to B as unsigned values.
- R6: Code 7 skips when A AND B is zero. Code 8 skips when A AND B is nonzero.
- R7: A skip whose condition holds gives `next_pc_o` = `pc_i` + 2 (wrapping) with `taken_o` = 1. A skip whose condition fails gives `next_pc_o` = `pc_i` with `taken_o` = 0.
- R8: With `use_imm_i` = 1, operand B is `imm4_i` zero-extended to 16 bits, and `opb_reg_i` has no effect.
- R9: Codes 9 to 15 are not control flow. They give `next_pc_o` = `pc_i` with `taken_o` = 0.
- R10: A cycle with `valid_i` = 0 gives `valid_o` = 0 and `taken_o` = 0 one clock later, and `next_pc_o` keeps its previous value.
- R11: The results of a request made while `valid_i` = 1 appear on the outputs exactly one clock later, with `valid_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Operation code (0 branch, 1..8 skips, 9..15 none) |
| use_imm_i | input | 1 | Take operand B from the 4-bit immediate |
| pc_i | input | 16 | Address of the following instruction |
| opa_i | input | 16 | Operand A |
| opb_reg_i | input | 16 | Operand B from a register |
| imm4_i | input | 4 | Unsigned immediate for operand B |
| offset_i | input | 11 | Signed branch displacement |
| next_pc_o | output | 16 | Registered next program counter |
| taken_o | output | 1 | Registered branch-or-skip-taken flag |
| valid_o | output | 1 | Registered result valid |

## Verification
Several corner cases are chosen to separate the signed and unsigned comparisons. One is 0xFFFF against 0x0001, where the two orderings give opposite answers. Another is 0x8000 against 0x7FFF, so a design that swapped the two comparison kinds or forgot the sign would skip in the wrong half of those cases. Negative displacements, including the most negative one, and program counters near 0xFFFE check that the offset is sign-extended and that the sum wraps instead of saturating. Immediate-operand cases use a register operand B that would flip the outcome, plus an immediate with its top bit set. These catch a design that read the register or sign-extended the immediate. Unused codes and idle cycles check that nothing is marked taken and that the held address does not move.

// File: rtl/skb_pkg.sv
package skb_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_BR  = 4'd0,
        OP_EQ  = 4'd1,
        OP_NE  = 4'd2,
        OP_LT  = 4'd3,
        OP_GE  = 4'd4,
        OP_LTU = 4'd5,
        OP_GEU = 4'd6,
        OP_BTC = 4'd7,
        OP_BTS = 4'd8
    } op_e;

endpackage

// File: rtl/skb_operand_sel.sv
module skb_operand_sel #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 4
) (
    input  logic [DATA_W-1:0] opb_reg_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    output logic [DATA_W-1:0] opb_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    // immediate is zero-extended
    assign imm_ext = {{PAD_W{1'b0}}, imm_i};

    always_comb begin
        opb_o = use_imm_i ? imm_ext : opb_reg_i;
    end
endmodule

// File: rtl/skb_cond_eval.sv
module skb_cond_eval
    import skb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              is_branch_o,
    output logic              skip_o
);
    logic eq_w;
    logic slt_w;
    logic ult_w;
    logic zand_w;
    op_e  op_w;

    assign op_w   = op_e'(op_i);
    assign eq_w   = (opa_i == opb_i);
    assign slt_w  = ($signed(opa_i) < $signed(opb_i));
    assign ult_w  = (opa_i < opb_i);
    assign zand_w = ((opa_i & opb_i) == '0);

    always_comb begin
        is_branch_o = 1'b0;
        skip_o      = 1'b0;
        case (op_w)
            OP_BR:   is_branch_o = 1'b1;
            OP_EQ:   skip_o = eq_w;
            OP_NE:   skip_o = ~eq_w;
            OP_LT:   skip_o = slt_w;
            OP_GE:   skip_o = ~slt_w;
            OP_LTU:  skip_o = ult_w;
            OP_GEU:  skip_o = ~ult_w;
            OP_BTC:  skip_o = zand_w;
            OP_BTS:  skip_o = ~zand_w;
            default: begin
                is_branch_o = 1'b0;
                skip_o      = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/skb_target_gen.sv
module skb_target_gen #(
    parameter int DATA_W     = 16,
    parameter int OFS_W      = 11,
    parameter int SKIP_BYTES = 2
) (
    input  logic [DATA_W-1:0] pc_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic              is_branch_i,
    input  logic              skip_i,
    output logic [DATA_W-1:0] target_o
);
    localparam logic [DATA_W-1:0] SKIP_INC = DATA_W'(SKIP_BYTES);

    logic [DATA_W-1:0] ofs_ext;
    logic [DATA_W-1:0] addend;

    assign ofs_ext[OFS_W-1:0] = offset_i;

    // replicate the sign bit into the upper positions
    generate
        for (genvar gi = OFS_W; gi < DATA_W; gi++) begin : g_sext
            assign ofs_ext[gi] = offset_i[OFS_W-1];
        end
    endgenerate

    always_comb begin
        if (is_branch_i)
            addend = ofs_ext;
        else if (skip_i)
            addend = SKIP_INC;
        else
            addend = '0;
        target_o = pc_i + addend;
    end
endmodule

// File: rtl/skip_branch_unit.sv
module skip_branch_unit
    import skb_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int OFS_W      = 11,
    parameter int IMM_W      = 4,
    parameter int SKIP_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_reg_i,
    input  logic [IMM_W-1:0]  imm4_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic [DATA_W-1:0] next_pc_o,
    output logic              taken_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [DATA_W-1:0] next_pc;
        logic              taken;
        logic              valid;
    } state_t;

    state_t            state_d;
    state_t            state_q;
    logic [DATA_W-1:0] opb_w;
    logic              is_branch_w;
    logic              skip_w;
    logic [DATA_W-1:0] target_w;

    skb_operand_sel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_opsel (
        .opb_reg_i (opb_reg_i),
        .imm_i     (imm4_i),
        .use_imm_i (use_imm_i),
        .opb_o     (opb_w)
    );

    skb_cond_eval #(
        .DATA_W (DATA_W)
    ) u_cond (
        .op_i        (op_i),
        .opa_i       (opa_i),
        .opb_i       (opb_w),
        .is_branch_o (is_branch_w),
        .skip_o      (skip_w)
    );

    skb_target_gen #(
        .DATA_W     (DATA_W),
        .OFS_W      (OFS_W),
        .SKIP_BYTES (SKIP_BYTES)
    ) u_target (
        .pc_i        (pc_i),
        .offset_i    (offset_i),
        .is_branch_i (is_branch_w),
        .skip_i      (skip_w),
        .target_o    (target_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = valid_i;
        state_d.taken = 1'b0;
        if (valid_i) begin
            state_d.next_pc = target_w;
            state_d.taken   = is_branch_w | skip_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign next_pc_o = state_q.next_pc;
    assign taken_o   = state_q.taken;
    assign valid_o   = state_q.valid;
endmodule

// File: rtl/skb_checker.sv
module skb_checker #(
    parameter int DATA_W     = 16,
    parameter int IMM_W      = 4,
    parameter int SKIP_BYTES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [3:0]        op_i,
    input logic              use_imm_i,
    input logic [DATA_W-1:0] pc_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_reg_i,
    input logic [IMM_W-1:0]  imm4_i,
    input logic [DATA_W-1:0] next_pc_o,
    input logic              taken_o,
    input logic              valid_o
);
    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && !taken_o && $stable(next_pc_o)));

    // R2
    branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd0) |=> taken_o);

    // R7
    skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i != 4'd0) |=>
        (next_pc_o == DATA_W'($past(pc_i) +
                       (taken_o ? DATA_W'(SKIP_BYTES) : DATA_W'(0)))));

    // R9
    undefined_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i > 4'd8) |=> !taken_o);

    // R3
    eq_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i && op_i == 4'd1 && opa_i == opb_reg_i) |=> taken_o);

    // R4
    lt_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i && op_i == 4'd3 &&
         $signed(opa_i) < $signed(opb_reg_i)) |=> taken_o);

    // R5
    geu_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !use_imm_i && op_i == 4'd6 && opa_i < opb_reg_i) |=> !taken_o);

    // R8
    bts_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && use_imm_i && op_i == 4'd8 &&
         (opa_i[IMM_W-1:0] & imm4_i) == '0) |=> !taken_o);
endmodule

bind skip_branch_unit skb_checker #(
    .DATA_W     (DATA_W),
    .IMM_W      (IMM_W),
    .SKIP_BYTES (SKIP_BYTES)
) u_skb_chk (.*);

// File: tb/skip_branch_unit_test.sv
`timescale 1ns/1ps
module skip_branch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic [3:0]  op_i;
    logic        use_imm_i;
    logic [15:0] pc_i;
    logic [15:0] opa_i;
    logic [15:0] opb_reg_i;
    logic [3:0]  imm4_i;
    logic [10:0] offset_i;
    logic [15:0] next_pc_o;
    logic        taken_o;
    logic        valid_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    skip_branch_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .op_i      (op_i),
        .use_imm_i (use_imm_i),
        .pc_i      (pc_i),
        .opa_i     (opa_i),
        .opb_reg_i (opb_reg_i),
        .imm4_i    (imm4_i),
        .offset_i  (offset_i),
        .next_pc_o (next_pc_o),
        .taken_o   (taken_o),
        .valid_o   (valid_o)
    );

    // {req, op, use_imm, pc, a, b, imm, ofs, exp_pc, exp_taken}
    localparam int NV = 27;
    localparam logic [88:0] VEC [NV] = '{
        {4'd2, 4'd0, 1'b0, 16'h0100, 16'h0000, 16'h0000, 4'h0, 11'h005, 16'h0105, 1'b1},
        {4'd2, 4'd0, 1'b0, 16'h0100, 16'h0000, 16'h0000, 4'h0, 11'h7FF, 16'h00FF, 1'b1},
        {4'd2, 4'd0, 1'b0, 16'h0002, 16'h0000, 16'h0000, 4'h0, 11'h400, 16'hFC02, 1'b1},
        {4'd2, 4'd0, 1'b0, 16'hFFFE, 16'h0000, 16'h0000, 4'h0, 11'h004, 16'h0002, 1'b1},
        {4'd3, 4'd1, 1'b0, 16'h0010, 16'h1234, 16'h1234, 4'h0, 11'h000, 16'h0012, 1'b1},
        {4'd3, 4'd1, 1'b0, 16'h0010, 16'h1234, 16'h1235, 4'h0, 11'h000, 16'h0010, 1'b0},
        {4'd3, 4'd2, 1'b0, 16'h0010, 16'h1234, 16'h1235, 4'h0, 11'h000, 16'h0012, 1'b1},
        {4'd3, 4'd2, 1'b0, 16'h0010, 16'h1234, 16'h1234, 4'h0, 11'h000, 16'h0010, 1'b0},
        {4'd4, 4'd3, 1'b0, 16'h0010, 16'hFFFF, 16'h0001, 4'h0, 11'h000, 16'h0012, 1'b1},
        {4'd4, 4'd3, 1'b0, 16'h0010, 16'h0001, 16'hFFFF, 4'h0, 11'h000, 16'h0010, 1'b0},
        {4'd4, 4'd4, 1'b0, 16'h0010, 16'h8000, 16'h8000, 4'h0, 11'h000, 16'h0012, 1'b1},
        {4'd4, 4'd4, 1'b0, 16'h0010, 16'h8000, 16'h7FFF, 4'h0, 11'h000, 16'h0010, 1'b0},
        {4'd5, 4'd5, 1'b0, 16'h0010, 16'hFFFF, 16'h0001, 4'h0, 11'h000, 16'h0010, 1'b0},
        {4'd5, 4'd5, 1'b0, 16'h0010, 16'h0001, 16'hFFFF, 4'h0, 11'h000, 16'h0012, 1'b1},
        {4'd5, 4'd6, 1'b0, 16'h0010, 16'h8000, 16'h7FFF, 4'h0, 11'h000, 16'h0012, 1'b1},
        {4'd5, 4'd6, 1'b0, 16'h0010, 16'h0000, 16'h0001, 4'h0, 11'h000, 16'h0010, 1'b0},
        {4'd6, 4'd7, 1'b0, 16'h0010, 16'h00F0, 16'h000F, 4'h0, 11'h000, 16'h0012, 1'b1},
        {4'd6, 4'd7, 1'b0, 16'h0010, 16'h00F0, 16'h0010, 4'h0, 11'h000, 16'h0010, 1'b0},
        {4'd6, 4'd8, 1'b0, 16'h0010, 16'h00F0, 16'h0010, 4'h0, 11'h000, 16'h0012, 1'b1},
        {4'd6, 4'd8, 1'b0, 16'h0010, 16'hAAAA, 16'h5555, 4'h0, 11'h000, 16'h0010, 1'b0},
        {4'd8, 4'd1, 1'b1, 16'h0010, 16'h0005, 16'h1234, 4'h5, 11'h000, 16'h0012, 1'b1},
        {4'd8, 4'd6, 1'b1, 16'h0010, 16'h000F, 16'hFFFF, 4'hF, 11'h000, 16'h0012, 1'b1},
        {4'd8, 4'd3, 1'b1, 16'h0010, 16'hFFFF, 16'h0000, 4'h8, 11'h000, 16'h0012, 1'b1},
        {4'd8, 4'd8, 1'b1, 16'h0010, 16'h0002, 16'hFFFF, 4'h1, 11'h000, 16'h0010, 1'b0},
        {4'd7, 4'd1, 1'b0, 16'hFFFE, 16'h0000, 16'h0000, 4'h0, 11'h000, 16'h0000, 1'b1},
        {4'd9, 4'd9, 1'b0, 16'h0040, 16'h0001, 16'h0002, 4'h0, 11'h123, 16'h0040, 1'b0},
        {4'd9, 4'd15,1'b0, 16'h0040, 16'h0003, 16'h0003, 4'h0, 11'h3FF, 16'h0040, 1'b0}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] op, input logic ui,
                         input logic [15:0] pc, input logic [15:0] a,
                         input logic [15:0] b, input logic [3:0] imm,
                         input logic [10:0] ofs);
        valid_i   = v;
        op_i      = op;
        use_imm_i = ui;
        pc_i      = pc;
        opa_i     = a;
        opb_reg_i = b;
        imm4_i    = imm;
        offset_i  = ofs;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        rst_n = 1'b0;
        drive(1'b0, 4'd0, 1'b0, 16'h0, 16'h0, 16'h0, 4'h0, 11'h0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", next_pc_o, 16'h0000);
        check("R1", {15'd0, taken_o}, 16'd0);
        check("R1", {15'd0, valid_o}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", next_pc_o, 16'h0000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][84:81], VEC[i][80], VEC[i][79:64], VEC[i][63:48],
                  VEC[i][47:32], VEC[i][31:28], VEC[i][27:17]);
            @(negedge clk);
            check(req_name(VEC[i][88:85]), next_pc_o, VEC[i][16:1]);
            check(req_name(VEC[i][88:85]), {15'd0, taken_o}, {15'd0, VEC[i][0]});
            check("R11", {15'd0, valid_o}, 16'd1);
        end

        // R10: idle cycle with a branch pattern on the data inputs
        drive(1'b1, 4'd0, 1'b0, 16'h2000, 16'h0, 16'h0, 4'h0, 11'h010);
        @(negedge clk);
        check("R2", next_pc_o, 16'h2010);
        held = next_pc_o;
        drive(1'b0, 4'd0, 1'b0, 16'h3000, 16'h0, 16'h0, 4'h0, 11'h020);
        @(negedge clk);
        check("R10", next_pc_o, held);
        check("R10", {15'd0, taken_o}, 16'd0);
        check("R10", {15'd0, valid_o}, 16'd0);
        @(negedge clk);
        check("R10", next_pc_o, held);

        // R11: one-cycle latency, not earlier
        drive(1'b1, 4'd1, 1'b0, 16'h0500, 16'h7, 16'h7, 4'h0, 11'h0);
        #1;
        check("R11", {15'd0, valid_o}, 16'd0);
        @(negedge clk);
        check("R11", next_pc_o, 16'h0502);
        check("R11", {15'd0, valid_o}, 16'd1);

        // R8: register operand ignored, immediate 0 vs register equal to A
        drive(1'b1, 4'd1, 1'b1, 16'h0600, 16'h0009, 16'h0009, 4'h0, 11'h0);
        @(negedge clk);
        check("R8", {15'd0, taken_o}, 16'd0);
        check("R8", next_pc_o, 16'h0600);

        // R1: reset mid-run clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", next_pc_o, 16'h0000);
        check("R1", {15'd0, valid_o}, 16'd0);
        rst_n = 1'b1;
        drive(1'b0, 4'd0, 1'b0, 16'h0, 16'h0, 16'h0, 4'h0, 11'h0);
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule